// File: doc/BRIEF.md
# PTM master time calculator

This block turns locally captured timestamps into the shared master time of a precision time hierarchy. A requester sends a time request and later receives a response. The block latches its free-running local counter at the cycle the request leaves (t1) and at the cycle the response arrives (t4). It keeps that pair until the next dialog completes.

The response of each later dialog carries two fields: the responder's master-time receive stamp t2' and the responder's turnaround delay (t3 − t2). When such a response arrives and a stored pair exists, the block computes the master time that corresponds to the stored t1. The result is t2' minus half of the round trip, with the turnaround taken out first. It also gives the difference between that master time and the stored t1.

The results are registered and flagged by a one-cycle valid pulse. An invalidate input discards all history, so the next completed dialog only primes the store. Message parsing is done elsewhere. The strobes and response fields reach this block already decoded.

Top module: `ptm_time_calc`

## Requirements
- R1: After reset, `result_valid` is 0, and `master_time` and `time_offset` are 0.
- R2: A `req_sent` pulse latches `local_time` as t1 and opens a dialog. A `rsp_rcvd` pulse while a dialog is open latches `local_time` as t4, closes the dialog and stores the (t1, t4) pair as history.
- R3: A completed dialog with no stored history gives no result (`result_valid` stays 0). This covers the first dialog after reset or invalidate. The dialog still stores its pair.
- R4: A `rsp_rcvd` that closes a dialog while history exists raises `result_valid` for exactly one cycle, on the clock edge after the pulse. `master_time` = t2' − floor(((t4h − t1h) − turn) / 2). Here t1h and t4h are the stored history pair, t2' is `rsp_master_rx` and turn is `rsp_turnaround`.
- R5: All timestamps are TS_W-bit (default 64) unsigned values, and every subtraction wraps modulo 2^TS_W. A local counter that wraps between t1 and t4 still gives the true round trip.
- R6: The net delay ((t4h − t1h) − turn) is read as a two's complement value and halved by rounding toward negative infinity. For example, a net delay of −3 gives −2.
- R7: `time_offset` = `master_time` − t1h (modulo 2^TS_W), and it is valid in the same cycle as `result_valid`.
- R8: A `rsp_rcvd` with no open dialog is ignored. It gives no result and leaves the history and outputs unchanged.
- R9: A `req_sent` while a dialog is open restarts the dialog: t1 is replaced with the newer counter value.
- R10: `invalidate` clears the open dialog, the history and `result_valid` on the next edge. It takes priority over a `req_sent` or `rsp_rcvd` in the same cycle.
- R11: `master_time` and `time_offset` keep their last computed values while `result_valid` is 0.
- R12: When `rsp_rcvd` and `req_sent` arrive in the same cycle with a dialog open, the response closes the old dialog (t4 = current counter). The request then opens a new dialog with t1 = the same counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_time | input | TS_W | Free-running local time counter |
| req_sent | input | 1 | One-cycle strobe: request transmitted |
| rsp_rcvd | input | 1 | One-cycle strobe: response received, fields valid |
| rsp_master_rx | input | TS_W | Responder master-time receive stamp t2' |
| rsp_turnaround | input | TS_W | Responder turnaround delay (t3 − t2) |
| invalidate | input | 1 | Discard open dialog and history |
| result_valid | output | 1 | One-cycle pulse: new result on outputs |
| master_time | output | TS_W | Computed master time at the stored t1 |
| time_offset | output | TS_W | Master time minus stored t1 |

## Verification
The bench targets several failure modes:
- Pairing: it checks that a result uses the previous dialog's stored pair and the current response's fields. A design that paired t1 and t4 from the current dialog would give wrong values on the second result.
- Rounding: it drives a turnaround larger than the round trip. An unsigned or truncating halving would then be off by one or by about 2^63.
- Wraparound: it wraps the local counter between t1 and t4 to expose a design that does not compute modulo 2^TS_W.
- Dialog control: it covers a stray response, a restarted request, a response and request in the same cycle, and an invalidate that coincides with a response. A design with the wrong priority would give a spurious result, keep stale history or lose the new t1.

// File: rtl/ptm_calc_pkg.sv
package ptm_calc_pkg;
    // Default width of every timestamp handled by the calculator.
    parameter int unsigned PTM_TS_W = 64;
endpackage

// File: rtl/ptm_calc_stamps.sv
module ptm_calc_stamps #(
    parameter int unsigned TS_W = ptm_calc_pkg::PTM_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] local_time_i,
    input  logic            req_sent_i,
    input  logic            rsp_rcvd_i,
    input  logic            invalidate_i,
    output logic            pend_o,
    output logic            hist_vld_o,
    output logic [TS_W-1:0] hist_t1_o,
    output logic [TS_W-1:0] hist_t4_o,
    output logic            fire_o
);
    typedef struct packed {
        logic            pend;
        logic [TS_W-1:0] cur_t1;
        logic            hist_vld;
        logic [TS_W-1:0] hist_t1;
        logic [TS_W-1:0] hist_t4;
    } stamp_st_t;

    stamp_st_t st_d, st_q;
    logic      close_dlg;

    assign close_dlg = rsp_rcvd_i && st_q.pend && !invalidate_i;

    always_comb begin
        st_d = st_q;
        if (invalidate_i) begin
            st_d = '0;
        end else begin
            if (close_dlg) begin
                st_d.hist_vld = 1'b1;
                st_d.hist_t1  = st_q.cur_t1;
                st_d.hist_t4  = local_time_i;
                st_d.pend     = 1'b0;
            end
            if (req_sent_i) begin
                st_d.pend   = 1'b1;
                st_d.cur_t1 = local_time_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o     = st_q.pend;
    assign hist_vld_o = st_q.hist_vld;
    assign hist_t1_o  = st_q.hist_t1;
    assign hist_t4_o  = st_q.hist_t4;
    assign fire_o     = close_dlg && st_q.hist_vld;

    assert_req_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sent_i && !invalidate_i) |=> pend_o);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate_i |=> (!pend_o && !hist_vld_o));

    assert_stray_keeps_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rcvd_i && !pend_o && !invalidate_i) |=> ($stable(hist_t1_o) && $stable(hist_t4_o)));
endmodule

// File: rtl/ptm_calc_math.sv
module ptm_calc_math #(
    parameter int unsigned TS_W = ptm_calc_pkg::PTM_TS_W
) (
    input  logic [TS_W-1:0] t1_i,
    input  logic [TS_W-1:0] t4_i,
    input  logic [TS_W-1:0] t2m_i,
    input  logic [TS_W-1:0] turn_i,
    output logic [TS_W-1:0] master_o,
    output logic [TS_W-1:0] offset_o
);
    logic [TS_W-1:0] round_trip;
    logic [TS_W-1:0] net_delay;
    logic [TS_W-1:0] half_delay;

    always_comb begin
        round_trip = t4_i - t1_i;
        net_delay  = round_trip - turn_i;
        // Sign-extending shift: floor division by two of a two's complement value.
        half_delay = {net_delay[TS_W-1], net_delay[TS_W-1:1]};
        master_o   = t2m_i - half_delay;
        offset_o   = master_o - t1_i;
    end
endmodule

// File: rtl/ptm_time_calc.sv
module ptm_time_calc #(
    parameter int unsigned TS_W = ptm_calc_pkg::PTM_TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] local_time,
    input  logic            req_sent,
    input  logic            rsp_rcvd,
    input  logic [TS_W-1:0] rsp_master_rx,
    input  logic [TS_W-1:0] rsp_turnaround,
    input  logic            invalidate,
    output logic            result_valid,
    output logic [TS_W-1:0] master_time,
    output logic [TS_W-1:0] time_offset
);
    typedef struct packed {
        logic            vld;
        logic [TS_W-1:0] master;
        logic [TS_W-1:0] offset;
    } out_st_t;

    logic            pend;
    logic            hist_vld;
    logic [TS_W-1:0] hist_t1;
    logic [TS_W-1:0] hist_t4;
    logic            fire;
    logic [TS_W-1:0] calc_master;
    logic [TS_W-1:0] calc_offset;
    out_st_t         out_d, out_q;

    ptm_calc_stamps #(.TS_W(TS_W)) u_stamps (
        .clk          (clk),
        .rst_n        (rst_n),
        .local_time_i (local_time),
        .req_sent_i   (req_sent),
        .rsp_rcvd_i   (rsp_rcvd),
        .invalidate_i (invalidate),
        .pend_o       (pend),
        .hist_vld_o   (hist_vld),
        .hist_t1_o    (hist_t1),
        .hist_t4_o    (hist_t4),
        .fire_o       (fire)
    );

    ptm_calc_math #(.TS_W(TS_W)) u_math (
        .t1_i     (hist_t1),
        .t4_i     (hist_t4),
        .t2m_i    (rsp_master_rx),
        .turn_i   (rsp_turnaround),
        .master_o (calc_master),
        .offset_o (calc_offset)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = fire;
        if (fire) begin
            out_d.master = calc_master;
            out_d.offset = calc_offset;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_valid = out_q.vld;
    assign master_time  = out_q.master;
    assign time_offset  = out_q.offset;

    assert_valid_needs_hist_R3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(hist_vld));

    assert_valid_after_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(rsp_rcvd && pend && !invalidate));

    assert_offset_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ((master_time - time_offset) == $past(hist_t1)));

    assert_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rcvd && !pend) |=> !result_valid);

    assert_inval_kills_R10: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !result_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(master_time) && $stable(time_offset)));
endmodule

// File: tb/ptm_time_calc_tb.sv
module ptm_time_calc_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] local_time = '0;
    logic         req_sent = 1'b0;
    logic         rsp_rcvd = 1'b0;
    logic [W-1:0] rsp_master_rx = '0;
    logic [W-1:0] rsp_turnaround = '0;
    logic         invalidate = 1'b0;
    logic         result_valid;
    logic [W-1:0] master_time;
    logic [W-1:0] time_offset;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Model of the dialog bookkeeping, taken from the requirements.
    bit           m_pend = 0;
    logic [W-1:0] m_cur = '0;
    bit           m_hv = 0;
    logic [W-1:0] m_t1 = '0;
    logic [W-1:0] m_t4 = '0;
    logic [W-1:0] last_m = '0;
    logic [W-1:0] last_o = '0;

    always #2.5 clk = ~clk;

    ptm_time_calc #(.TS_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .local_time(local_time),
        .req_sent(req_sent), .rsp_rcvd(rsp_rcvd),
        .rsp_master_rx(rsp_master_rx), .rsp_turnaround(rsp_turnaround),
        .invalidate(invalidate), .result_valid(result_valid),
        .master_time(master_time), .time_offset(time_offset)
    );

    function automatic logic [W-1:0] exp_master(logic [W-1:0] t1, logic [W-1:0] t4,
                                                 logic [W-1:0] t2m, logic [W-1:0] turn);
        logic [W-1:0] net;
        longint       n;
        longint       h;
        net = (t4 - t1) - turn;
        n   = longint'(net);
        if (n < 0) h = -((-n + 1) / 2);
        else       h = n / 2;
        return t2m - W'(h);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(logic [W-1:0] t);
        @(negedge clk);
        local_time = t; req_sent = 1'b1;
        @(negedge clk);
        req_sent = 1'b0;
        m_pend = 1; m_cur = t;
    endtask

    // Response; checks the result one edge later against the model.
    task automatic do_rsp(string req, logic [W-1:0] t4, logic [W-1:0] t2m, logic [W-1:0] turn);
        bit           exp_v;
        logic [W-1:0] em;
        logic [W-1:0] eo;
        exp_v = m_pend && m_hv;
        em = last_m; eo = last_o;
        if (exp_v) begin
            em = exp_master(m_t1, m_t4, t2m, turn);
            eo = em - m_t1;
        end
        @(negedge clk);
        local_time = t4; rsp_rcvd = 1'b1; rsp_master_rx = t2m; rsp_turnaround = turn;
        @(negedge clk);
        rsp_rcvd = 1'b0;
        check({req, " valid"}, W'(result_valid), W'(exp_v));
        check({req, " master"}, master_time, em);
        check({req, " offset"}, time_offset, eo);
        @(negedge clk);
        check({req, " pulse ends"}, W'(result_valid), '0);
        if (m_pend) begin
            m_hv = 1; m_t1 = m_cur; m_t4 = t4; m_pend = 0;
        end
        last_m = em; last_o = eo;
    endtask

    task automatic do_inval();
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        check("R10 valid low", W'(result_valid), '0);
        m_pend = 0; m_hv = 0; m_t1 = '0; m_t4 = '0;
    endtask

    task automatic t_reset();
        check("R1 valid", W'(result_valid), '0);
        check("R1 master", master_time, '0);
        check("R1 offset", time_offset, '0);
    endtask

    task automatic t_basic();
        do_req(64'd100);
        do_rsp("R3 first dialog", 64'd300, 64'd9999, 64'd7);
        do_req(64'd400);
        // pair (100,300), turn 50: net 150, half 75, master 4925, offset 4825
        do_rsp("R4 second dialog", 64'd650, 64'd5000, 64'd50);
        check("R4 master value", last_m, 64'd4925);
        check("R7 offset value", last_o, 64'd4825);
        do_req(64'd1000);
        do_rsp("R2 third dialog", 64'd1200, 64'd80000, 64'd20);
    endtask

    task automatic t_wrap();
        do_inval();
        do_req(64'hFFFF_FFFF_FFFF_FFEC);
        do_rsp("R3 after inval", 64'd30, 64'd1, 64'd1);
        do_req(64'd40);
        // rtt 50, turn 10 -> half 20
        do_rsp("R5 wrap", 64'd90, 64'd7000, 64'd10);
        check("R5 wrap master", last_m, 64'd6980);
    endtask

    task automatic t_negative();
        do_req(64'd1000);
        do_rsp("R6 prime", 64'd1010, 64'd0, 64'd0);
        do_req(64'd1100);
        // rtt 10 turn 13 -> net -3 -> half -2 -> master t2'+2
        do_rsp("R6 negative net", 64'd1200, 64'd500, 64'd13);
        check("R6 floor", last_m, 64'd502);
    endtask

    task automatic t_stray_and_hold();
        // no open dialog: ignored, outputs hold
        do_rsp("R8 stray", 64'd77777, 64'd123456, 64'd3);
        check("R11 hold master", master_time, last_m);
        do_req(64'd2000);
        do_rsp("R8 history kept", 64'd2100, 64'd9000, 64'd4);
    endtask

    task automatic t_restart();
        do_req(64'd3000);
        do_req(64'd3050);
        do_rsp("R9 restart", 64'd3200, 64'd100000, 64'd0);
        do_req(64'd3300);
        do_rsp("R9 uses newer t1", 64'd3400, 64'd200000, 64'd10);
        // pair (3050,3200): net 140 half 70
        check("R9 value", last_m, 64'd199930);
    endtask

    task automatic t_same_cycle();
        do_req(64'd5000);
        // response and request together
        @(negedge clk);
        local_time = 64'd5200; rsp_rcvd = 1'b1; req_sent = 1'b1;
        rsp_master_rx = 64'd1000; rsp_turnaround = 64'd0;
        begin
            logic [W-1:0] em;
            em = exp_master(m_t1, m_t4, 64'd1000, 64'd0);
            @(negedge clk);
            rsp_rcvd = 1'b0; req_sent = 1'b0;
            check("R12 valid", W'(result_valid), 64'd1);
            check("R12 master", master_time, em);
            last_m = em; last_o = em - m_t1;
        end
        m_hv = 1; m_t1 = 64'd5000; m_t4 = 64'd5200; m_pend = 1; m_cur = 64'd5200;
        do_rsp("R12 new dialog", 64'd5300, 64'd40000, 64'd0);
        // pair (5000,5200): half 100
        check("R12 pair", last_m, 64'd39900);
    endtask

    task automatic t_inval_priority();
        do_req(64'd6000);
        @(negedge clk);
        local_time = 64'd6100; rsp_rcvd = 1'b1; invalidate = 1'b1;
        @(negedge clk);
        rsp_rcvd = 1'b0; invalidate = 1'b0;
        check("R10 priority valid", W'(result_valid), '0);
        check("R10 outputs held", master_time, last_m);
        m_pend = 0; m_hv = 0;
        do_req(64'd7000);
        do_rsp("R10 no history", 64'd7100, 64'd1, 64'd0);
        do_req(64'd7200);
        do_rsp("R10 rebuilt", 64'd7300, 64'd60000, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_wrap();
        t_negative();
        t_stray_and_hold();
        t_restart();
        t_same_cycle();
        t_inval_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=hung exp=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule